// File: doc/BRIEF.md
# Shared-Bus Serial Lane Interleaver

This block sequences byte traffic between one command/data byte stream and a bank of single-pin shift lanes. The lanes are not wired to the sequencer one by one. They all hang off a single internal bus with a 4-bit lane address and an 8-bit data path. A host first loads an interleave list of up to eight entries. Each entry names a lane and says whether that lane drives its pin or samples it. The host then issues a transfer that carries a count of whole 8-bit words and a count of leftover bits for one final partial word.

Each step of a transfer runs in a fixed order:
- Collect one byte from the input stream for every driving entry.
- Walk the list over the bus to arm every listed lane.
- Fire all armed lanes together, so their pins shift in lockstep, LSB first, one bit per clock.
- Wait until every lane reports ready.
- Walk the list again to read the sampled bytes.
- Hand those bytes to the response stream in list order.

If the host needs a pin to change direction inside a word, it splits the transfer into partial words and issues a new setup at the change.

Top module: `lane_interleaver`

## Requirements
- R1: After reset, all pin enables and pin outputs are low, no response is offered, and a command byte is accepted.
- R2: A setup command is the byte 01xxxnnn, with nnn+1 entries to follow. In each entry byte, bit 4 set means the lane drives its pin and bit 4 clear means it samples its pin. Bits 3:0 give the lane address.
- R3: A transfer command is the byte 10xxxxxx, followed by a whole-word count byte and then a byte whose bits 2:0 give the leftover bit count. The whole words run first, then one partial word if the leftover count is nonzero.
- R4: Within a step, driving lanes take input bytes in list order, and sampled bytes leave on the response stream in list order.
- R5: All lanes in a step shift together, one bit per clock, least significant bit first. A sampling lane stores the bit it sees on the clock that a driving lane presents that bit.
- R6: A partial word shifts only the stated number of bits. Unused sampled bits read as zero, and a driving pin holds its last shifted bit afterwards.
- R7: A lane's pin enable follows the direction that the list gave it when it was last armed, and it stays stable while any lane is shifting.
- R8: When the input stream is empty or the response stream is blocked, the sequencer stalls between steps only. No pin shifts and no further input byte is taken while it waits.
- R9: A transfer with zero words and zero leftover bits arms no lane, produces no response, and is followed at once by acceptance of the next command.
- R10: Command bytes whose top two bits are 00 or 11 are consumed with no effect.
- R11: Lanes absent from the list keep their pin and pin enable unchanged.
- R12: The bus arms a lane only when every lane reports ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Input stream byte present |
| in_data | input | 8 | Input stream byte (commands and driving data) |
| in_ready | output | 1 | Input byte taken on this clock |
| rsp_valid | output | 1 | Response byte offered |
| rsp_data | output | 8 | Response byte |
| rsp_ready | input | 1 | Response stream can take a byte |
| pin_i | input | NUM_LANES | Sampled pin levels, one per lane |
| pin_o | output | NUM_LANES | Driven pin levels, one per lane |
| pin_oe | output | NUM_LANES | Pin drive enables, one per lane |

## Verification
A wrong list index or output counter hands a byte to the wrong lane. Because the bench loops each driving pin back to a sampling lane, this shows up at the response port in the same step, within about twenty clocks. A lane whose bit counter or shift direction is off changes the returned byte, and also the number of clocks a lone set bit stays high on its pin. A stall taken in the wrong place shows up as an input byte taken too early, or as pin activity while the response stream is blocked. Both are visible in the clocks right after the blockage begins.

// File: rtl/lil_pkg.sv
package lil_pkg;

    localparam int BUS_ADDR_W = 4;
    localparam int BUS_DATA_W = 8;

    localparam logic [1:0] OPC_SETUP = 2'b01;
    localparam logic [1:0] OPC_XFER  = 2'b10;

    typedef enum logic [3:0] {
        S_CMD,
        S_SETUP,
        S_WCNT,
        S_FBITS,
        S_NEXT,
        S_GATHER,
        S_WRITE,
        S_GO,
        S_WAIT,
        S_READ,
        S_DRAIN
    } seq_state_e;

    typedef struct packed {
        logic                  drive;
        logic [BUS_ADDR_W-1:0] lane;
    } seq_entry_t;

endpackage

// File: rtl/lil_lane.sv
module lil_lane
    import lil_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic                  wr_drive,
    input  logic [BUS_DATA_W-1:0] wr_data,
    input  logic                  go,
    input  logic [3:0]            go_bits,
    input  logic                  pin_i,
    output logic                  pin_o,
    output logic                  pin_oe,
    output logic [BUS_DATA_W-1:0] rd_data,
    output logic                  ready
);

    typedef struct packed {
        logic                  armed;
        logic                  busy;
        logic                  drive;
        logic [BUS_DATA_W-1:0] sh;
        logic [BUS_DATA_W-1:0] cap;
        logic [3:0]            cnt;
        logic [2:0]            idx;
        logic                  last;
    } lane_st_t;

    lane_st_t q, d;

    always_comb begin
        d = q;
        if (wr_en) begin
            d.armed = 1'b1;
            d.drive = wr_drive;
            d.sh    = wr_data;
            d.cap   = '0;
        end else if (go && q.armed) begin
            d.armed = 1'b0;
            d.busy  = (go_bits != 4'd0);
            d.cnt   = go_bits;
            d.idx   = 3'd0;
        end else if (q.busy) begin
            if (q.drive) begin
                d.last = q.sh[0];
                d.sh   = q.sh >> 1;
            end else begin
                d.cap[q.idx] = pin_i;
            end
            d.idx = q.idx + 3'd1;
            d.cnt = q.cnt - 4'd1;
            if (q.cnt == 4'd1) begin
                d.busy = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else begin
            q <= d;
        end
    end

    assign pin_o   = (q.busy && q.drive) ? q.sh[0] : q.last;
    assign pin_oe  = q.drive;
    assign rd_data = q.cap;
    assign ready   = !q.busy;

endmodule

// File: rtl/lil_rdmux.sv
module lil_rdmux
    import lil_pkg::*;
#(
    parameter int NUM_LANES = 8
) (
    input  logic [BUS_ADDR_W-1:0]                 addr,
    input  logic [NUM_LANES-1:0][BUS_DATA_W-1:0]  lane_rd,
    output logic [BUS_DATA_W-1:0]                 rdata
);

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            if (addr == BUS_ADDR_W'(i)) begin
                rdata = lane_rd[i];
            end
        end
    end

endmodule

// File: rtl/lil_seq.sv
module lil_seq
    import lil_pkg::*;
#(
    parameter int SEQ_MAX = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [7:0]            in_data,
    output logic                  in_ready,
    output logic                  rsp_valid,
    output logic [7:0]            rsp_data,
    input  logic                  rsp_ready,
    input  logic                  lanes_ready,
    output logic                  bus_we,
    output logic                  bus_drive,
    output logic [BUS_ADDR_W-1:0] bus_addr,
    output logic [BUS_DATA_W-1:0] bus_wdata,
    input  logic [BUS_DATA_W-1:0] bus_rdata,
    output logic                  bus_go,
    output logic [3:0]            go_bits
);

    localparam int IDX_W = (SEQ_MAX > 1) ? $clog2(SEQ_MAX) : 1;
    localparam int CNT_W = IDX_W + 1;
    localparam logic [CNT_W-1:0] C_ONE = CNT_W'(1);
    localparam logic [IDX_W-1:0] I_ONE = IDX_W'(1);

    typedef struct packed {
        seq_state_e                           st;
        seq_entry_t [SEQ_MAX-1:0]             ent;
        logic [CNT_W-1:0]                     len;
        logic [CNT_W-1:0]                     n_out;
        logic [CNT_W-1:0]                     n_in;
        logic [CNT_W-1:0]                     k;
        logic [IDX_W-1:0]                     ix;
        logic [7:0]                           words;
        logic [2:0]                           frac;
        logic [3:0]                           bits;
        logic [SEQ_MAX-1:0][BUS_DATA_W-1:0]   obuf;
        logic [SEQ_MAX-1:0][BUS_DATA_W-1:0]   ibuf;
    } seq_st_t;

    seq_st_t q, d;

    seq_entry_t       cur_ent;
    logic             walk_last;
    logic [IDX_W-1:0] k_idx;

    assign cur_ent   = q.ent[q.ix];
    assign walk_last = ({1'b0, q.ix} == (q.len - C_ONE));
    assign k_idx     = q.k[IDX_W-1:0];

    always_comb begin
        d         = q;
        in_ready  = 1'b0;
        rsp_valid = 1'b0;
        rsp_data  = q.ibuf[k_idx];
        bus_we    = 1'b0;
        bus_drive = 1'b0;
        bus_addr  = '0;
        bus_wdata = '0;
        bus_go    = 1'b0;
        go_bits   = q.bits;

        unique case (q.st)
            S_CMD: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    if (in_data[7:6] == OPC_SETUP) begin
                        d.len   = CNT_W'(in_data[IDX_W-1:0]) + C_ONE;
                        d.k     = '0;
                        d.n_out = '0;
                        d.n_in  = '0;
                        d.st    = S_SETUP;
                    end else if (in_data[7:6] == OPC_XFER) begin
                        d.st = S_WCNT;
                    end
                end
            end
            S_SETUP: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    d.ent[k_idx].drive = in_data[4];
                    d.ent[k_idx].lane  = in_data[3:0];
                    if (in_data[4]) begin
                        d.n_out = q.n_out + C_ONE;
                    end else begin
                        d.n_in = q.n_in + C_ONE;
                    end
                    d.k = q.k + C_ONE;
                    if (q.k == q.len - C_ONE) begin
                        d.st = S_CMD;
                    end
                end
            end
            S_WCNT: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    d.words = in_data;
                    d.st    = S_FBITS;
                end
            end
            S_FBITS: begin
                in_ready = 1'b1;
                if (in_valid) begin
                    d.frac = in_data[2:0];
                    d.st   = S_NEXT;
                end
            end
            S_NEXT: begin
                d.k = '0;
                if (q.words != 8'd0) begin
                    d.words = q.words - 8'd1;
                    d.bits  = 4'd8;
                    d.st    = S_GATHER;
                end else if (q.frac != 3'd0) begin
                    d.bits = {1'b0, q.frac};
                    d.frac = 3'd0;
                    d.st   = S_GATHER;
                end else begin
                    d.st = S_CMD;
                end
            end
            S_GATHER: begin
                if (q.k == q.n_out) begin
                    d.k  = '0;
                    d.ix = '0;
                    d.st = S_WRITE;
                end else begin
                    in_ready = 1'b1;
                    if (in_valid) begin
                        d.obuf[k_idx] = in_data;
                        d.k           = q.k + C_ONE;
                    end
                end
            end
            S_WRITE: begin
                bus_we    = 1'b1;
                bus_drive = cur_ent.drive;
                bus_addr  = cur_ent.lane;
                bus_wdata = cur_ent.drive ? q.obuf[k_idx] : '0;
                if (cur_ent.drive) begin
                    d.k = q.k + C_ONE;
                end
                if (walk_last) begin
                    d.k  = '0;
                    d.st = S_GO;
                end else begin
                    d.ix = q.ix + I_ONE;
                end
            end
            S_GO: begin
                bus_go = 1'b1;
                d.st   = S_WAIT;
            end
            S_WAIT: begin
                if (lanes_ready) begin
                    d.ix = '0;
                    d.k  = '0;
                    d.st = S_READ;
                end
            end
            S_READ: begin
                bus_addr = cur_ent.lane;
                if (!cur_ent.drive) begin
                    d.ibuf[k_idx] = bus_rdata;
                    d.k           = q.k + C_ONE;
                end
                if (walk_last) begin
                    d.k  = '0;
                    d.st = S_DRAIN;
                end else begin
                    d.ix = q.ix + I_ONE;
                end
            end
            S_DRAIN: begin
                if (q.k == q.n_in) begin
                    d.st = S_NEXT;
                end else begin
                    rsp_valid = 1'b1;
                    if (rsp_ready) begin
                        d.k = q.k + C_ONE;
                    end
                end
            end
            default: d.st = S_CMD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_CMD;
        end else begin
            q <= d;
        end
    end

endmodule

// File: rtl/lane_interleaver.sv
module lane_interleaver
    import lil_pkg::*;
#(
    parameter int NUM_LANES = 8,
    parameter int SEQ_MAX   = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [7:0]           in_data,
    output logic                 in_ready,
    output logic                 rsp_valid,
    output logic [7:0]           rsp_data,
    input  logic                 rsp_ready,
    input  logic [NUM_LANES-1:0] pin_i,
    output logic [NUM_LANES-1:0] pin_o,
    output logic [NUM_LANES-1:0] pin_oe
);

    logic                                 bus_we;
    logic                                 bus_drive;
    logic [BUS_ADDR_W-1:0]                bus_addr;
    logic [BUS_DATA_W-1:0]                bus_wdata;
    logic [BUS_DATA_W-1:0]                bus_rdata;
    logic                                 bus_go;
    logic [3:0]                           go_bits;
    logic [NUM_LANES-1:0]                 lane_ready;
    logic [NUM_LANES-1:0][BUS_DATA_W-1:0] lane_rd;
    logic                                 lanes_ready;

    assign lanes_ready = &lane_ready;

    lil_seq #(
        .SEQ_MAX (SEQ_MAX)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .in_valid    (in_valid),
        .in_data     (in_data),
        .in_ready    (in_ready),
        .rsp_valid   (rsp_valid),
        .rsp_data    (rsp_data),
        .rsp_ready   (rsp_ready),
        .lanes_ready (lanes_ready),
        .bus_we      (bus_we),
        .bus_drive   (bus_drive),
        .bus_addr    (bus_addr),
        .bus_wdata   (bus_wdata),
        .bus_rdata   (bus_rdata),
        .bus_go      (bus_go),
        .go_bits     (go_bits)
    );

    for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
        logic sel;
        assign sel = bus_we && (bus_addr == BUS_ADDR_W'(g));

        lil_lane u_lane (
            .clk      (clk),
            .rst_n    (rst_n),
            .wr_en    (sel),
            .wr_drive (bus_drive),
            .wr_data  (bus_wdata),
            .go       (bus_go),
            .go_bits  (go_bits),
            .pin_i    (pin_i[g]),
            .pin_o    (pin_o[g]),
            .pin_oe   (pin_oe[g]),
            .rd_data  (lane_rd[g]),
            .ready    (lane_ready[g])
        );
    end

    lil_rdmux #(
        .NUM_LANES (NUM_LANES)
    ) u_rdmux (
        .addr    (bus_addr),
        .lane_rd (lane_rd),
        .rdata   (bus_rdata)
    );

endmodule

// File: rtl/lil_checker.sv
module lil_checker #(
    parameter int NUM_LANES = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 bus_we,
    input logic                 bus_go,
    input logic                 lanes_ready,
    input logic                 in_ready,
    input logic                 rsp_valid,
    input logic                 rsp_ready,
    input logic [7:0]           rsp_data,
    input logic [NUM_LANES-1:0] pin_oe
);

    AST_ARM_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> lanes_ready);                                       // R12

    AST_NO_POP_IN_WALK: assert property (@(posedge clk) disable iff (!rst_n)
        bus_we |-> !in_ready);                                         // R8

    AST_GO_AFTER_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        bus_go |-> $past(bus_we));                                     // R4

    AST_RSP_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_data))); // R8

    AST_OE_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !lanes_ready |=> $stable(pin_oe));                             // R7

endmodule

bind lane_interleaver lil_checker #(.NUM_LANES(NUM_LANES)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .bus_we      (bus_we),
    .bus_go      (bus_go),
    .lanes_ready (lanes_ready),
    .in_ready    (in_ready),
    .rsp_valid   (rsp_valid),
    .rsp_ready   (rsp_ready),
    .rsp_data    (rsp_data),
    .pin_oe      (pin_oe)
);

// File: tb/tb_lane_interleaver.sv
`timescale 1ns/100ps
module tb_lane_interleaver;

    localparam int NL = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          in_valid = 1'b0;
    logic [7:0]    in_data = 8'h00;
    logic          in_ready;
    logic          rsp_valid;
    logic [7:0]    rsp_data;
    logic          rsp_ready = 1'b1;
    logic [NL-1:0] pin_i;
    logic [NL-1:0] pin_o;
    logic [NL-1:0] pin_oe;

    always #2 clk = ~clk;

    // loopback: lane k samples the pin driven by lane k-2
    assign pin_i = {pin_o[NL-3:0], pin_o[NL-1:NL-2]};

    lane_interleaver #(.NUM_LANES(NL), .SEQ_MAX(8)) dut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready),
        .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
        .pin_i(pin_i), .pin_o(pin_o), .pin_oe(pin_oe)
    );

    int       vec = 0;
    int       fail = 0;
    int       rsp_n = 0;
    int       pop_n = 0;
    int       high_cnt = 0;
    logic     trace_en = 1'b0;
    logic [7:0] rlog [256];

    always begin
        @(negedge clk);
        #1.5;
        if (rsp_valid && rsp_ready) begin
            rlog[rsp_n[7:0]] = rsp_data;
            rsp_n++;
        end
        if (in_valid && in_ready) pop_n++;
        if (trace_en && pin_o[0]) high_cnt++;
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        vec++;
        if (act !== exp) begin
            fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = b;
        #1;
        while (!in_ready) begin
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        #1;
        in_valid = 1'b0;
    endtask

    function automatic logic [7:0] drv(input int l);
        return 8'h10 | 8'(l);
    endfunction

    function automatic logic [7:0] smp(input int l);
        return 8'(l);
    endfunction

    task automatic xfer(input logic [7:0] words, input logic [7:0] frac);
        send(8'h80);
        send(words);
        send(frac);
    endtask

    task automatic wait_rsp(input int target);
        for (int i = 0; i < 2000 && rsp_n < target; i++) @(negedge clk);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic t_reset();
        #1;
        chk("R1 pin_oe", 32'(pin_oe), 0);
        chk("R1 pin_o", 32'(pin_o), 0);
        chk("R1 rsp_valid", 32'(rsp_valid), 0);
        chk("R1 in_ready", 32'(in_ready), 1);
    endtask

    task automatic t_basic();
        int b = rsp_n;
        send(8'h43); send(drv(0)); send(drv(1)); send(smp(2)); send(smp(3)); // R2
        xfer(8'd2, 8'd0);                                                   // R3
        send(8'hA5); send(8'h3C); send(8'h96); send(8'h0F);
        wait_rsp(b + 4);
        chk("R3 count", 32'(rsp_n - b), 4);
        chk("R4 rsp0", 32'(rlog[b]),   32'h A5);
        chk("R4 rsp1", 32'(rlog[b+1]), 32'h 3C);
        chk("R4 rsp2", 32'(rlog[b+2]), 32'h 96);
        chk("R4 rsp3", 32'(rlog[b+3]), 32'h 0F);
        chk("R7 oe", 32'(pin_oe), 32'h03);
    endtask

    task automatic t_order();
        int b = rsp_n;
        send(8'h43); send(smp(3)); send(drv(1)); send(smp(2)); send(drv(0));
        xfer(8'd1, 8'd0);
        send(8'h11); send(8'h22);
        wait_rsp(b + 2);
        chk("R4 order0", 32'(rlog[b]),   32'h11);
        chk("R4 order1", 32'(rlog[b+1]), 32'h22);
    endtask

    task automatic t_lsb();
        send(8'h40); send(drv(0));
        xfer(8'd1, 8'd0); send(8'h00);
        idle(30);
        high_cnt = 0;
        trace_en = 1'b1;
        xfer(8'd1, 8'd0); send(8'h01);
        idle(30);
        trace_en = 1'b0;
        chk("R5 lsb first high cycles", 32'(high_cnt), 1);
        chk("R5 pin after", 32'(pin_o[0]), 0);
    endtask

    task automatic t_frac();
        int b = rsp_n;
        send(8'h41); send(drv(0)); send(smp(2));
        xfer(8'd0, 8'd3); send(8'hFE);
        wait_rsp(b + 1);
        idle(4);
        chk("R6 partial rsp", 32'(rlog[b]), 32'h06);
        chk("R6 pin holds", 32'(pin_o[0]), 1);
        xfer(8'd1, 8'd5); send(8'h5A); send(8'hFF);
        wait_rsp(b + 3);
        chk("R6 whole then partial a", 32'(rlog[b+1]), 32'h5A);
        chk("R6 whole then partial b", 32'(rlog[b+2]), 32'h1F);
    endtask

    task automatic t_zero();
        int b = rsp_n;
        logic [NL-1:0] oe0;
        send(8'h41); send(drv(4)); send(smp(6));
        oe0 = pin_oe;
        xfer(8'd0, 8'd0);
        idle(10);
        chk("R9 oe untouched", 32'(pin_oe), 32'(oe0));
        chk("R9 no rsp", 32'(rsp_n - b), 0);
        chk("R9 next accepted", 32'(in_ready), 1);
        xfer(8'd1, 8'd0); send(8'h77);
        wait_rsp(b + 1);
        chk("R9 follow-on rsp", 32'(rlog[b]), 32'h77);
        chk("R7 lane4 drives", 32'(pin_oe[4]), 1);
        chk("R11 lane5 oe", 32'(pin_oe[5]), 0);
        chk("R11 lane5 pin", 32'(pin_o[5]), 0);
    endtask

    task automatic t_stall_in();
        int b = rsp_n;
        int moved = 0;
        logic p0;
        send(8'h41); send(drv(0)); send(smp(2));
        xfer(8'd2, 8'd0); send(8'h81);
        idle(40);
        chk("R8 one step done", 32'(rsp_n - b), 1);
        chk("R8 first byte", 32'(rlog[b]), 32'h81);
        p0 = pin_o[0];
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (pin_o[0] !== p0) moved++;
        end
        chk("R8 pins quiet while starved", 32'(moved), 0);
        send(8'h42);
        wait_rsp(b + 2);
        chk("R8 resumed", 32'(rlog[b+1]), 32'h42);
    endtask

    task automatic t_stall_rsp();
        int b = rsp_n;
        int p;
        @(negedge clk);
        rsp_ready = 1'b0;
        xfer(8'd2, 8'd0);
        p = pop_n;
        send(8'h33);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = 8'h44;
        idle(40);
        chk("R8 no pop while blocked", 32'(pop_n - p), 1);
        chk("R8 rsp offered", 32'(rsp_valid), 1);
        chk("R8 rsp data", 32'(rsp_data), 32'h33);
        rsp_ready = 1'b1;
        for (int i = 0; i < 200 && (pop_n - p) < 2; i++) @(negedge clk);
        in_valid = 1'b0;
        wait_rsp(b + 2);
        chk("R8 drained a", 32'(rlog[b]), 32'h33);
        chk("R8 drained b", 32'(rlog[b+1]), 32'h44);
    endtask

    task automatic t_unknown();
        int b = rsp_n;
        logic [NL-1:0] oe0;
        oe0 = pin_oe;
        send(8'hC5); send(8'h00); send(8'h3F);
        idle(6);
        chk("R10 oe same", 32'(pin_oe), 32'(oe0));
        chk("R10 no rsp", 32'(rsp_n - b), 0);
        xfer(8'd1, 8'd0); send(8'h9C);
        wait_rsp(b + 1);
        chk("R10 list kept", 32'(rlog[b]), 32'h9C);
    endtask

    initial begin
        #(4 * 150000);
        fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", vec, fail);
        $finish;
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_basic();
        t_order();
        t_lsb();
        t_frac();
        t_zero();
        t_stall_in();
        t_stall_rsp();
        t_unknown();
        idle(5);
        $display("== %0d vectors applied, %0d miscompares ==", vec, fail);
        $finish;
    end

endmodule